// File: doc/BRIEF.md
# Memory-Card SPI-Mode Bring-Up Sequencer

This block is the control state machine that takes a removable memory card from power-up to a state where single-block transfers can begin over an SPI link. After a start pulse it asks a byte shifter for a run of idle clocking bytes, sent with the card deselected. It then works through the identification handshake by issuing command requests (a 6-bit index, a 32-bit argument and a CRC byte) to a separate command framer. It reads back the 8-bit status byte that the framer returns, or the framer's timeout flag.

The status of the interface-condition query picks one of two readiness loops. The version-1 loop sends the application prefix followed by the operating-condition command with a zero argument. The version-2 loop wraps the same pair with an operating-condition-register read and sets the high-capacity support bit in the argument. Both loops have an iteration limit. When identification succeeds, the sequencer fixes the block length at 512 bytes, reports how block numbers must be scaled into addresses and selects the fast serial clock. The outcome is held until the next start.

Top module: `sdspi_init_seq`

## Requirements
- R1: After reset `busy`, `done`, `cmd_req`, `dummy_req`, `fast_clk_sel` and `addr_byte_mode` are 0 and `result` is 2'b00 (failure code).
- R2: A start request first issues exactly PREAMBLE_BYTES idle-byte requests on `dummy_req`/`dummy_ack`, sent with the card deselected at the slow clock. No command is requested before the last one has been acknowledged, and `cmd_req` and `dummy_req` are never high together.
- R3: The first command is index 0 with argument 0 and CRC byte 8'h95. Any status other than exactly 8'h01 ends the run with the failure code.
- R4: The next command is index 8 with argument 32'h0000_01AA and CRC byte 8'h87. Status 8'h01 selects the version-2 loop, status 8'h05 selects the version-1 loop, and any other status ends with the failure code.
- R5: The version-1 loop repeats index 55 (argument 0) then index 41 (argument 0) until index 41 returns 8'h00. It then sets `addr_byte_mode`=1 (addresses scaled by 512), and a successful run reports `result`=2'b01.
- R6: The version-2 loop repeats index 58, index 55, then index 41 with argument 32'h4000_0000 until index 41 returns 8'h00. One more index 58 follows, `addr_byte_mode` is set to 0 (block addressing), and a successful run reports `result`=2'b10. The code 2'b11 is reserved for a high-capacity outcome and is not produced.
- R7: Each loop issues index 41 at most RETRY_MAX times. A non-zero status on the RETRY_MAX-th one ends with the failure code and no further command.
- R8: After identification, index 16 with argument 512 is issued. A non-zero status ends with the failure code. A zero status raises `fast_clk_sel`, which is 0 during every run.
- R9: A response with `rsp_timeout`=1 counts as a wrong status at index 0, 8, 41 and 16. The status and timeout returned for index 55 and index 58 do not affect the sequence.
- R10: `done` is a one-cycle pulse in the cycle in which `busy` first reads 0. `result` then holds until the next accepted start, which clears `result` to 2'b00 and `fast_clk_sel` and `addr_byte_mode` to 0. Outside a run no request is raised.
- R11: A start pulse while `busy`=1 has no effect on the command sequence or the outcome.
- R12: A command request stays raised with unchanged index, argument and CRC until the cycle in which `rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin bring-up (ignored while busy) |
| dummy_req | output | 1 | Request one idle byte sent with the card deselected |
| dummy_ack | input | 1 | Idle byte sent |
| cmd_req | output | 1 | Command request to the framer |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | CRC/end byte of the command |
| rsp_valid | input | 1 | Response for the current command is present |
| rsp_status | input | 8 | First status byte returned by the card |
| rsp_timeout | input | 1 | No status byte arrived in time |
| fast_clk_sel | output | 1 | 1 selects the transfer clock, 0 the slow bring-up clock |
| addr_byte_mode | output | 1 | 1: scale block numbers by 512; 0: use block numbers |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 failure, 01 version 1, 10 version 2 |

## Verification
The bench builds the sequencer with PREAMBLE_BYTES=4 and RETRY_MAX=6 instead of 16 and 5000. This keeps the preamble count visible and makes loop exhaustion reachable in a few hundred cycles. It covers a card that answers on the last allowed iteration, one that never answers, and early exits at every checked step. It also covers timeouts and ignored statuses on the prefix and register-read commands.

// File: rtl/sdspi_init_pkg.sv
package sdspi_init_pkg;

    typedef enum logic [1:0] {
        RES_FAIL = 2'b00,
        RES_V1   = 2'b01,
        RES_V2   = 2'b10,
        RES_HC   = 2'b11
    } card_res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_GO_IDLE,
        ST_IF_COND,
        ST_V1_APP,
        ST_V1_OP,
        ST_V2_OCR,
        ST_V2_APP,
        ST_V2_OP,
        ST_V2_OCR_END,
        ST_BLKLEN
    } seq_st_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  crc;
    } cmd_fields_t;

    localparam logic [7:0]  STAT_IDLE         = 8'h01;
    localparam logic [7:0]  STAT_IDLE_ILLEGAL = 8'h05;
    localparam logic [7:0]  STAT_READY        = 8'h00;
    localparam logic [31:0] ARG_IF_COND       = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS           = 32'h4000_0000;
    localparam logic [31:0] ARG_BLOCK_LEN     = 32'd512;
    localparam logic [7:0]  CRC_FIXED         = 8'h95;
    localparam logic [7:0]  CRC_IF_COND       = 8'h87;

    function automatic logic is_cmd_state(seq_st_e s);
        return (s != ST_IDLE) && (s != ST_PRE);
    endfunction

endpackage

// File: rtl/sdspi_cmd_table.sv
module sdspi_cmd_table
    import sdspi_init_pkg::*;
(
    input  seq_st_e     st,
    output cmd_fields_t fields,
    output logic        active
);
    always_comb begin
        fields = '{idx: 6'd0, arg: 32'd0, crc: CRC_FIXED};
        active = is_cmd_state(st);
        case (st)
            ST_GO_IDLE:    fields.idx = 6'd0;
            ST_IF_COND:    begin fields.idx = 6'd8;  fields.arg = ARG_IF_COND; fields.crc = CRC_IF_COND; end
            ST_V1_APP,
            ST_V2_APP:     fields.idx = 6'd55;
            ST_V1_OP:      fields.idx = 6'd41;
            ST_V2_OP:      begin fields.idx = 6'd41; fields.arg = ARG_HCS; end
            ST_V2_OCR,
            ST_V2_OCR_END: fields.idx = 6'd58;
            ST_BLKLEN:     begin fields.idx = 6'd16; fields.arg = ARG_BLOCK_LEN; end
            default:       fields = '{idx: 6'd0, arg: 32'd0, crc: CRC_FIXED};
        endcase
    end
endmodule

// File: rtl/sdspi_step_counter.sv
module sdspi_step_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (inc && !at_last)
            cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
    import sdspi_init_pkg::*;
#(
    parameter int PREAMBLE_BYTES = 16,
    parameter int RETRY_MAX      = 5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        dummy_req,
    input  logic        dummy_ack,
    output logic        cmd_req,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    output logic [7:0]  cmd_crc,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_status,
    input  logic        rsp_timeout,
    output logic        fast_clk_sel,
    output logic        addr_byte_mode,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result
);
    seq_st_e     state;
    card_res_e   res_q, ident_q;
    cmd_fields_t fields;
    logic        cmd_active, pre_last, retry_last;
    logic        fast_q, addr_q, done_q;
    logic        rsp_ok;

    assign rsp_ok = rsp_valid && !rsp_timeout;

    sdspi_cmd_table u_table (
        .st     (state),
        .fields (fields),
        .active (cmd_active)
    );

    sdspi_step_counter #(.LIMIT(PREAMBLE_BYTES)) u_pre_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == ST_IDLE),
        .inc     ((state == ST_PRE) && dummy_ack),
        .at_last (pre_last)
    );

    sdspi_step_counter #(.LIMIT(RETRY_MAX)) u_retry_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == ST_IF_COND),
        .inc     (rsp_valid && ((state == ST_V1_OP) || (state == ST_V2_OP))),
        .at_last (retry_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            res_q   <= RES_FAIL;
            ident_q <= RES_FAIL;
            fast_q  <= 1'b0;
            addr_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_PRE;
                    res_q  <= RES_FAIL;
                    fast_q <= 1'b0;
                    addr_q <= 1'b0;
                end
                ST_PRE: if (dummy_ack && pre_last) state <= ST_GO_IDLE;
                ST_GO_IDLE: if (rsp_valid) begin
                    if (rsp_ok && rsp_status == STAT_IDLE) state <= ST_IF_COND;
                    else begin state <= ST_IDLE; done_q <= 1'b1; end
                end
                ST_IF_COND: if (rsp_valid) begin
                    if (rsp_ok && rsp_status == STAT_IDLE) state <= ST_V2_OCR;
                    else if (rsp_ok && rsp_status == STAT_IDLE_ILLEGAL) state <= ST_V1_APP;
                    else begin state <= ST_IDLE; done_q <= 1'b1; end
                end
                ST_V1_APP: if (rsp_valid) state <= ST_V1_OP;
                ST_V1_OP: if (rsp_valid) begin
                    if (rsp_ok && rsp_status == STAT_READY) begin
                        addr_q  <= 1'b1;
                        ident_q <= RES_V1;
                        state   <= ST_BLKLEN;
                    end else if (retry_last) begin
                        state <= ST_IDLE; done_q <= 1'b1;
                    end else state <= ST_V1_APP;
                end
                ST_V2_OCR: if (rsp_valid) state <= ST_V2_APP;
                ST_V2_APP: if (rsp_valid) state <= ST_V2_OP;
                ST_V2_OP: if (rsp_valid) begin
                    if (rsp_ok && rsp_status == STAT_READY) state <= ST_V2_OCR_END;
                    else if (retry_last) begin
                        state <= ST_IDLE; done_q <= 1'b1;
                    end else state <= ST_V2_OCR;
                end
                ST_V2_OCR_END: if (rsp_valid) begin
                    addr_q  <= 1'b0;
                    ident_q <= RES_V2;
                    state   <= ST_BLKLEN;
                end
                ST_BLKLEN: if (rsp_valid) begin
                    if (rsp_ok && rsp_status == STAT_READY) begin
                        res_q  <= ident_q;
                        fast_q <= 1'b1;
                    end
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dummy_req      = (state == ST_PRE);
    assign cmd_req        = cmd_active;
    assign cmd_idx        = fields.idx;
    assign cmd_arg        = fields.arg;
    assign cmd_crc        = fields.crc;
    assign fast_clk_sel   = fast_q;
    assign addr_byte_mode = addr_q;
    assign busy           = (state != ST_IDLE);
    assign done           = done_q;
    assign result         = res_q;
endmodule

// File: rtl/sdspi_init_chk.sv
module sdspi_init_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        dummy_req,
    input logic        dummy_ack,
    input logic        cmd_req,
    input logic [5:0]  cmd_idx,
    input logic [31:0] cmd_arg,
    input logic [7:0]  cmd_crc,
    input logic        rsp_valid,
    input logic [7:0]  rsp_status,
    input logic        rsp_timeout,
    input logic        fast_clk_sel,
    input logic        addr_byte_mode,
    input logic        busy,
    input logic        done,
    input logic [1:0]  result
);
    p_one_req_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_req && dummy_req));

    p_slow_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fast_clk_sel);

    p_fast_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_clk_sel) |-> (done && result != 2'b00));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_req && !dummy_req));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(addr_byte_mode)));

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !rsp_valid) |=> busy);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !rsp_valid) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_arg) && $stable(cmd_crc)));

    p_ack_only_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        dummy_ack |-> dummy_req);

    p_status_known_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_timeout) |-> !$isunknown(rsp_status));
endmodule

bind sdspi_init_seq sdspi_init_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .dummy_req(dummy_req), .dummy_ack(dummy_ack),
    .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_timeout(rsp_timeout),
    .fast_clk_sel(fast_clk_sel), .addr_byte_mode(addr_byte_mode), .busy(busy),
    .done(done), .result(result)
);

// File: tb/sim_sdspi_init_seq.sv
module sim_sdspi_init_seq;
    localparam int PRE   = 4;
    localparam int RETRY = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dummy_req, dummy_ack;
    logic        cmd_req;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_crc;
    logic        rsp_valid, rsp_timeout;
    logic [7:0]  rsp_status;
    logic        fast_clk_sel, addr_byte_mode, busy, done;
    logic [1:0]  result;

    always #5 clk = ~clk;

    sdspi_init_seq #(.PREAMBLE_BYTES(PRE), .RETRY_MAX(RETRY)) u0 (
        .clk(clk), .rst(rst), .start(start), .dummy_req(dummy_req), .dummy_ack(dummy_ack),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_timeout(rsp_timeout),
        .fast_clk_sel(fast_clk_sel), .addr_byte_mode(addr_byte_mode), .busy(busy),
        .done(done), .result(result)
    );

    int checks = 0;
    int failures = 0;

    // card scenario
    logic [7:0] s_cmd0, s_cmd8, s_cmd16;
    int         s_ready;
    bit         s_to0, s_to55, s_to16;
    int         n41, n_dummy;
    bit         cmd_before_pre_done;

    int          got_idx[$];
    logic [31:0] got_arg[$];
    logic [7:0]  got_crc[$];
    int          exp_q[$];
    logic [1:0]  exp_res;
    bit          exp_fast, exp_ident, exp_v2;

    logic        prev_req, prev_rsp;
    logic [5:0]  prev_idx;
    logic [31:0] prev_arg;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // card responder and per-clock comparison
    initial begin
        rsp_valid = 0; dummy_ack = 0; rsp_status = 8'hFF; rsp_timeout = 0;
        prev_req = 0; prev_rsp = 0; prev_idx = 0; prev_arg = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                rsp_valid = 0; dummy_ack = 0;
            end else begin
                if (busy) chk(!fast_clk_sel, "R8", "fast clock during run", fast_clk_sel, 0);
                if (!busy) chk(!cmd_req && !dummy_req, "R10", "request while idle", {cmd_req, dummy_req}, 0);
                if (prev_req && !prev_rsp)
                    chk(cmd_req && cmd_idx == prev_idx && cmd_arg == prev_arg, "R12",
                        "request not held", {cmd_req, cmd_idx}, {1'b1, prev_idx});
                prev_req = cmd_req; prev_idx = cmd_idx; prev_arg = cmd_arg;
                if (rsp_valid || dummy_ack) begin
                    rsp_valid = 0; dummy_ack = 0;
                end else if (dummy_req) begin
                    dummy_ack = 1; n_dummy++;
                end else if (cmd_req) begin
                    if (n_dummy != PRE) cmd_before_pre_done = 1;
                    got_idx.push_back(int'(cmd_idx));
                    got_arg.push_back(cmd_arg);
                    got_crc.push_back(cmd_crc);
                    rsp_timeout = 0;
                    case (cmd_idx)
                        6'd0:  begin rsp_status = s_cmd0; rsp_timeout = s_to0; end
                        6'd8:  rsp_status = s_cmd8;
                        6'd55: begin rsp_status = 8'h7E; rsp_timeout = s_to55; end
                        6'd58: rsp_status = 8'h3C;
                        6'd41: begin n41++; rsp_status = (s_ready != 0 && n41 >= s_ready) ? 8'h00 : 8'h01; end
                        6'd16: begin rsp_status = s_cmd16; rsp_timeout = s_to16; end
                        default: rsp_status = 8'h04;
                    endcase
                    rsp_valid = 1;
                end
                prev_rsp = rsp_valid;
            end
        end
    end

    task automatic build_exp();
        exp_q.delete();
        exp_res = 2'b00; exp_fast = 0; exp_ident = 0; exp_v2 = 0;
        exp_q.push_back(0);
        if (!s_to0 && s_cmd0 == 8'h01) begin
            exp_q.push_back(8);
            if (s_cmd8 == 8'h01 || s_cmd8 == 8'h05) begin
                exp_v2 = (s_cmd8 == 8'h01);
                for (int i = 1; i <= RETRY; i++) begin
                    if (exp_v2) exp_q.push_back(58);
                    exp_q.push_back(55);
                    exp_q.push_back(41);
                    if (s_ready == i) begin exp_ident = 1; break; end
                end
                if (exp_ident) begin
                    if (exp_v2) exp_q.push_back(58);
                    exp_q.push_back(16);
                    if (!s_to16 && s_cmd16 == 8'h00) begin
                        exp_res = exp_v2 ? 2'b10 : 2'b01;
                        exp_fast = 1;
                    end
                end
            end
        end
    endtask

    function automatic logic [31:0] exp_arg(int idx, bit v2);
        case (idx)
            8:  return 32'h0000_01AA;
            16: return 32'd512;
            41: return v2 ? 32'h4000_0000 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic run_case(input string name, input string req, input bit poke_start);
        bit seq_ok, arg_ok, crc_ok;
        got_idx.delete(); got_arg.delete(); got_crc.delete();
        n41 = 0; n_dummy = 0; cmd_before_pre_done = 0;
        build_exp();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke_start) begin
            repeat (12) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        chk(!busy, "R10", {name, " busy at done"}, busy, 0);
        chk(result == exp_res, req, {name, " result"}, result, exp_res);
        chk(fast_clk_sel == exp_fast, "R8", {name, " clock select"}, fast_clk_sel, exp_fast);
        if (exp_ident)
            chk(addr_byte_mode == !exp_v2, exp_v2 ? "R6" : "R5", {name, " address mode"},
                addr_byte_mode, !exp_v2);
        chk(n_dummy == PRE && !cmd_before_pre_done, "R2", {name, " idle bytes"}, n_dummy, PRE);
        seq_ok = (got_idx.size() == exp_q.size());
        arg_ok = 1; crc_ok = 1;
        for (int i = 0; i < got_idx.size() && seq_ok; i++) begin
            if (got_idx[i] != exp_q[i]) seq_ok = 0;
            if (got_arg[i] != exp_arg(got_idx[i], exp_v2)) arg_ok = 0;
            if (got_idx[i] == 0 && got_crc[i] != 8'h95) crc_ok = 0;
            if (got_idx[i] == 8 && got_crc[i] != 8'h87) crc_ok = 0;
        end
        chk(seq_ok, req, {name, " command sequence length"}, got_idx.size(), exp_q.size());
        chk(arg_ok, "R4", {name, " command arguments"}, arg_ok, 1);
        chk(crc_ok, "R3", {name, " CRC bytes"}, crc_ok, 1);
        @(negedge clk);
        chk(!done, "R10", {name, " done width"}, done, 0);
        chk(result == exp_res, "R10", {name, " result hold"}, result, exp_res);
    endtask

    task automatic scen(input logic [7:0] c0, input logic [7:0] c8, input int rdy,
                        input logic [7:0] c16, input bit t0, input bit t55, input bit t16);
        s_cmd0 = c0; s_cmd8 = c8; s_ready = rdy; s_cmd16 = c16;
        s_to0 = t0; s_to55 = t55; s_to16 = t16;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        scen(8'h01, 8'h05, 1, 8'h00, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !cmd_req && !dummy_req && !fast_clk_sel && !addr_byte_mode && result == 2'b00,
            "R1", "reset state", {busy, done, cmd_req, dummy_req, fast_clk_sel, addr_byte_mode, result}, 0);

        scen(8'h01, 8'h05, 3, 8'h00, 0, 0, 0); run_case("v1 ready on 3rd", "R5", 0);
        scen(8'h01, 8'h01, 2, 8'h00, 0, 0, 0); run_case("v2 ready on 2nd", "R6", 0);
        scen(8'h00, 8'h01, 1, 8'h00, 0, 0, 0); run_case("bad reset status", "R3", 0);
        scen(8'h01, 8'h09, 1, 8'h00, 0, 0, 0); run_case("bad query status", "R4", 0);
        scen(8'h01, 8'h05, 0, 8'h00, 0, 0, 0); run_case("v1 never ready", "R7", 0);
        scen(8'h01, 8'h01, RETRY, 8'h00, 0, 0, 0); run_case("v2 ready on last", "R7", 0);
        scen(8'h01, 8'h01, 0, 8'h00, 0, 0, 0); run_case("v2 never ready", "R7", 0);
        scen(8'h01, 8'h05, 1, 8'h04, 0, 0, 0); run_case("block length rejected", "R8", 0);
        scen(8'h01, 8'h05, 1, 8'h00, 1, 0, 0); run_case("timeout at reset", "R9", 0);
        scen(8'h01, 8'h05, 2, 8'h00, 0, 1, 0); run_case("prefix timeout ignored", "R9", 0);
        scen(8'h01, 8'h01, 1, 8'h00, 0, 0, 1); run_case("timeout at block length", "R9", 0);
        scen(8'h01, 8'h01, 3, 8'h00, 0, 0, 0); run_case("start while busy", "R11", 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule